// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block takes a single asynchronous serial line and turns each frame into a byte for the host side. A frame is a low start bit, eight data bits with the least significant bit first, an optional parity bit, and one high stop bit. The line rests high between frames. An external enable tick runs at sixteen times the bit rate. The receiver confirms the start bit at its middle. It then samples every following bit at its middle.

A finished frame moves from the shift register into a holding register, and a data-full flag is set. If the host has not yet taken the previous byte, the new one is dropped and an overrun flag is set. A low stop bit sets a framing flag, and a parity mismatch sets a parity flag. In both of those cases the byte is still stored.

Two interrupt request lines share one enable. One follows the data-full flag and the other follows any error flag. The host clears the data-full flag with one single-cycle strobe and all error flags with a second strobe.

Top module: `async_rx_unit`

## Requirements
- R1: With a tick every fourth clock, a frame sent at 16 ticks per bit is received, with bit 0 of `rx_data` taken from the first data bit after the start bit.
- R2: When a frame completes and `rx_full` is 0, the byte is loaded into `rx_data` and `rx_full` becomes 1.
- R3: When a frame completes while `rx_full` is 1, `ovr_err` becomes 1 and `rx_data` keeps the earlier byte.
- R4: A stop bit sampled as 0 sets `frm_err` and the byte is still loaded. No new frame starts until the line has been seen high again.
- R5: With `par_en`=1, `par_odd`=0 selects even parity, meaning the count of ones over the data and parity bits is even. `par_odd`=1 selects odd parity. A mismatch sets `par_err`, and the byte is still loaded.
- R6: With `par_en`=0 no parity bit is expected, the stop bit follows D7 directly, and `par_err` is never set.
- R7: `irq_data` is 1 exactly when `rx_full` is 1 and `irq_en` was 1 on the previous clock.
- R8: `irq_err` is 1 exactly when any of `ovr_err`, `frm_err` or `par_err` is 1 and `irq_en` was 1 on the previous clock.
- R9: A one-cycle `clr_full` pulse clears `rx_full`. A one-cycle `clr_err` pulse clears all three error flags.
- R10: A low pulse that has ended by the middle of the start bit is rejected, and no frame is received.
- R11: After reset all flags, both interrupt requests and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Serial line, idle high |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| irq_en | input | 1 | Shared interrupt enable |
| clr_full | input | 1 | Strobe that clears the data-full flag |
| clr_err | input | 1 | Strobe that clears all error flags |
| rx_data | output | 8 | Holding register for the received byte |
| rx_full | output | 1 | Data-full flag |
| ovr_err | output | 1 | Overrun flag |
| frm_err | output | 1 | Framing flag |
| par_err | output | 1 | Parity flag |
| irq_data | output | 1 | Receive-data interrupt request |
| irq_err | output | 1 | Receive-error interrupt request |

## Verification
The hardest case to reach from the ports is a frame with a low stop bit. At that point the line is still low when the receiver goes back to idle, and a careless design would take it for a new start bit. The bench sends such a frame and holds the line low for the whole stop bit. It then waits several bit times and checks that exactly one byte arrived and no stray frame followed. The overrun case works the same way: two frames are sent back to back with no clear between them, and the check confirms that the first byte survives.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_t;
endpackage

// File: rtl/async_rx_sampler.sv
module async_rx_sampler
  import async_rx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rxd,
  input  logic          par_en,
  input  logic          par_odd,
  output logic          done,
  output logic [DW-1:0] word,
  output logic          stop_bad,
  output logic          par_bad
);
  localparam int CW = $clog2(OVS);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] HALF_END = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] BIT_END  = CW'(OVS - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  rx_state_t     state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [DW-1:0] sh;
  logic          rx_m, rx_s, armed, pbit;

  // two-flop synchronizer
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      sh       <= '0;
      armed    <= 1'b0;
      pbit     <= 1'b0;
      done     <= 1'b0;
      word     <= '0;
      stop_bad <= 1'b0;
      par_bad  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (state)
          RX_IDLE: begin
            // a start needs a high-to-low transition seen on ticks
            if (rx_s) armed <= 1'b1;
            else if (armed) begin
              armed <= 1'b0;
              state <= RX_START;
              cnt   <= '0;
            end
          end
          RX_START: begin
            if (cnt == HALF_END) begin
              cnt <= '0;
              if (rx_s) begin
                state <= RX_IDLE;
                armed <= 1'b1;
              end else begin
                state <= RX_DATA;
                bitn  <= '0;
              end
            end else cnt <= cnt + 1'b1;
          end
          RX_DATA: begin
            if (cnt == BIT_END) begin
              cnt <= '0;
              sh  <= {rx_s, sh[DW-1:1]};
              if (bitn == LAST_BIT) state <= par_en ? RX_PAR : RX_STOP;
              else bitn <= bitn + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          RX_PAR: begin
            if (cnt == BIT_END) begin
              cnt   <= '0;
              pbit  <= rx_s;
              state <= RX_STOP;
            end else cnt <= cnt + 1'b1;
          end
          RX_STOP: begin
            if (cnt == BIT_END) begin
              cnt      <= '0;
              done     <= 1'b1;
              word     <= sh;
              stop_bad <= ~rx_s;
              par_bad  <= par_en & (^sh ^ pbit ^ par_odd);
              armed    <= 1'b0;
              state    <= RX_IDLE;
            end else cnt <= cnt + 1'b1;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  // R1: a completion pulse lasts a single clock
  a_r1_single_done: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/async_rx_status.sv
module async_rx_status #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          done,
  input  logic [DW-1:0] word,
  input  logic          stop_bad,
  input  logic          par_bad,
  input  logic          irq_en,
  input  logic          clr_full,
  input  logic          clr_err,
  output logic [DW-1:0] rx_data,
  output logic          rx_full,
  output logic          ovr_err,
  output logic          frm_err,
  output logic          par_err,
  output logic          irq_data,
  output logic          irq_err
);
  logic full_n, ovr_n, frm_n, par_n, ld;

  always_comb begin
    full_n = rx_full & ~clr_full;
    ovr_n  = ovr_err & ~clr_err;
    frm_n  = frm_err & ~clr_err;
    par_n  = par_err & ~clr_err;
    ld     = 1'b0;
    if (done) begin
      if (full_n) ovr_n = 1'b1;
      else begin
        ld     = 1'b1;
        full_n = 1'b1;
        frm_n  = frm_n | stop_bad;
        par_n  = par_n | par_bad;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data  <= '0;
      rx_full  <= 1'b0;
      ovr_err  <= 1'b0;
      frm_err  <= 1'b0;
      par_err  <= 1'b0;
      irq_data <= 1'b0;
      irq_err  <= 1'b0;
    end else begin
      if (ld) rx_data <= word;
      rx_full  <= full_n;
      ovr_err  <= ovr_n;
      frm_err  <= frm_n;
      par_err  <= par_n;
      irq_data <= full_n & irq_en;
      irq_err  <= (ovr_n | frm_n | par_n) & irq_en;
    end
  end

  // R2: an empty register takes the finished byte
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    (done && !rx_full) |=> (rx_full && rx_data == $past(word)));
  // R3: overrun keeps the earlier byte
  a_r3_keep_old: assert property (@(posedge clk) disable iff (rst)
    (done && rx_full && !clr_full) |=> (ovr_err && $stable(rx_data)));
  // R9: error clear strobe empties all error flags
  a_r9_clear_err: assert property (@(posedge clk) disable iff (rst)
    (clr_err && !done) |=> (!ovr_err && !frm_err && !par_err));
  // R7: data request follows the flag under the enable
  a_r7_irq_data: assert property (@(posedge clk) disable iff (rst)
    irq_data == (rx_full && $past(irq_en)));
  // R8: error request follows any error flag under the enable
  a_r8_irq_err: assert property (@(posedge clk) disable iff (rst)
    irq_err == ((ovr_err || frm_err || par_err) && $past(irq_en)));
endmodule

// File: rtl/async_rx_unit.sv
module async_rx_unit #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rxd,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          irq_en,
  input  logic          clr_full,
  input  logic          clr_err,
  output logic [DW-1:0] rx_data,
  output logic          rx_full,
  output logic          ovr_err,
  output logic          frm_err,
  output logic          par_err,
  output logic          irq_data,
  output logic          irq_err
);
  logic          done, stop_bad, par_bad;
  logic [DW-1:0] word;

  async_rx_sampler #(.OVS(OVS), .DW(DW)) u_smp (
    .clk(clk), .rst(rst), .tick(tick), .rxd(rxd),
    .par_en(par_en), .par_odd(par_odd),
    .done(done), .word(word), .stop_bad(stop_bad), .par_bad(par_bad)
  );

  async_rx_status #(.DW(DW)) u_sts (
    .clk(clk), .rst(rst), .done(done), .word(word),
    .stop_bad(stop_bad), .par_bad(par_bad), .irq_en(irq_en),
    .clr_full(clr_full), .clr_err(clr_err),
    .rx_data(rx_data), .rx_full(rx_full), .ovr_err(ovr_err),
    .frm_err(frm_err), .par_err(par_err),
    .irq_data(irq_data), .irq_err(irq_err)
  );
endmodule

// File: tb/sim_async_rx_unit.sv
`timescale 1ns/1ps
module sim_async_rx_unit;
  localparam int BITC = 64; // 16 ticks x 4 clocks

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxd = 1'b1;
  logic par_en = 1'b0, par_odd = 1'b0, irq_en = 1'b0;
  logic clr_full = 1'b0, clr_err = 1'b0;
  logic [1:0] tc = 2'd0;
  logic tick;
  logic [7:0] rx_data;
  logic rx_full, ovr_err, frm_err, par_err, irq_data, irq_err;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;
  always @(negedge clk) tc <= tc + 2'd1;
  assign tick = (tc == 2'd0);

  async_rx_unit u0 (
    .clk(clk), .rst(rst), .tick(tick), .rxd(rxd), .par_en(par_en),
    .par_odd(par_odd), .irq_en(irq_en), .clr_full(clr_full), .clr_err(clr_err),
    .rx_data(rx_data), .rx_full(rx_full), .ovr_err(ovr_err), .frm_err(frm_err),
    .par_err(par_err), .irq_data(irq_data), .irq_err(irq_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic line(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic with_par, input logic pb, input logic stopv);
    line(1'b0, BITC);
    for (int i = 0; i < 8; i++) line(b[i], BITC);
    if (with_par) line(pb, BITC);
    line(stopv, BITC);
    line(1'b1, 3 * BITC);
  endtask

  task automatic pulse_full();
    clr_full = 1'b1; @(negedge clk); clr_full = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_err();
    clr_err = 1'b1; @(negedge clk); clr_err = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 rx_data", rx_data, 0);
    chk("R11 flags", {rx_full, ovr_err, frm_err, par_err}, 0);
    chk("R11 irqs", {irq_data, irq_err}, 0);
  endtask

  task automatic t_basic();
    irq_en = 1'b1; par_en = 1'b0;
    send(8'hA5, 1'b0, 1'b0, 1'b1);
    chk("R1 byte LSB first", rx_data, 8'hA5);
    chk("R2 full set", rx_full, 1);
    chk("R7 irq_data", irq_data, 1);
    chk("R8 no irq_err", irq_err, 0);
    chk("R6 par_err clear", par_err, 0);
    pulse_full();
    chk("R9 full cleared", rx_full, 0);
    chk("R7 irq_data drops", irq_data, 0);
    send(8'h01, 1'b0, 1'b0, 1'b1);
    chk("R1 second byte", rx_data, 8'h01);
    pulse_full();
  endtask

  task automatic t_overrun();
    send(8'h3C, 1'b0, 1'b0, 1'b1);
    send(8'h5A, 1'b0, 1'b0, 1'b1);
    chk("R3 old data kept", rx_data, 8'h3C);
    chk("R3 ovr_err", ovr_err, 1);
    chk("R8 irq_err", irq_err, 1);
    pulse_err();
    chk("R9 errors cleared", {ovr_err, frm_err, par_err}, 0);
    chk("R8 irq_err drops", irq_err, 0);
    chk("R9 full untouched by clr_err", rx_full, 1);
    pulse_full();
  endtask

  task automatic t_frame();
    send(8'h81, 1'b0, 1'b0, 1'b0);
    chk("R4 frm_err", frm_err, 1);
    chk("R4 data loaded", rx_data, 8'h81);
    chk("R4 full", rx_full, 1);
    chk("R4 no stray frame", ovr_err, 0);
    pulse_full(); pulse_err();
    repeat (4 * BITC) @(negedge clk);
    chk("R4 no restart from low stop", rx_full, 0);
  endtask

  task automatic t_parity();
    par_en = 1'b1; par_odd = 1'b0;
    send(8'h07, 1'b1, 1'b1, 1'b1);
    chk("R5 even ok", par_err, 0);
    chk("R5 byte", rx_data, 8'h07);
    pulse_full();
    send(8'h07, 1'b1, 1'b0, 1'b1);
    chk("R5 even mismatch", par_err, 1);
    chk("R5 byte loaded on error", {rx_full, rx_data}, 9'h107);
    pulse_full(); pulse_err();
    par_odd = 1'b1;
    send(8'h36, 1'b1, 1'b1, 1'b1);
    chk("R5 odd ok", par_err, 0);
    chk("R5 odd byte", rx_data, 8'h36);
    pulse_full();
    send(8'h36, 1'b1, 1'b0, 1'b1);
    chk("R5 odd mismatch", par_err, 1);
    pulse_full(); pulse_err();
    par_en = 1'b0; par_odd = 1'b0;
    send(8'hFE, 1'b0, 1'b0, 1'b1);
    chk("R6 no parity bit", rx_data, 8'hFE);
    chk("R6 par_err never", par_err, 0);
    pulse_full();
  endtask

  task automatic t_irq_off();
    irq_en = 1'b0;
    send(8'h44, 1'b0, 1'b0, 1'b0);
    chk("R7 masked data irq", {rx_full, irq_data}, 2'b10);
    chk("R8 masked err irq", {frm_err, irq_err}, 2'b10);
    irq_en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 unmasked", irq_data, 1);
    chk("R8 unmasked", irq_err, 1);
    pulse_full(); pulse_err();
  endtask

  task automatic t_glitch();
    line(1'b0, 12);
    line(1'b1, 12 * BITC);
    chk("R10 glitch rejected", rx_full, 0);
    send(8'hC3, 1'b0, 1'b0, 1'b1);
    chk("R10 receive after glitch", rx_data, 8'hC3);
    pulse_full();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    repeat (2 * BITC) @(negedge clk);
    t_basic();
    t_overrun();
    t_frame();
    t_parity();
    t_irq_off();
    t_glitch();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule